// File: doc/BRIEF.md
# Streaming Complex Magnitude with Aligned Bin Index

This block turns a stream of complex spectral samples into a stream of magnitudes. Each clock it may accept one sample made of a signed real part, a signed imaginary part, a valid flag, a frame-end flag and a bin number. It returns the magnitude of that sample together with the same bin number and frame-end flag. It never stalls and has no ready signal, so the upstream transform can stream straight into it.

A parameter picks one of two arithmetic variants. The exact variant squares both parts, adds the squares and takes the integer square root. The root is built in a pipeline that resolves one result bit per stage and uses the non-restoring method. The cheap variant adds the two absolute values. This is a rough estimate that is good enough for tasks such as peak picking and costs no multipliers. In both variants the valid flag, the frame-end flag and the bin number pass through a shift register. That shift register is exactly as deep as the arithmetic path, so a reported peak never lands on a neighbouring bin.

Top module: `cmag_unit`

## Requirements
- R1: In exact mode, every valid output carries floor(sqrt(Re*Re + Im*Im)) of its own input sample. A new sample can be accepted on every clock.
- R2: In exact mode, an output appears 2 + DATA_W clock edges after the edge that accepted the sample: 2 for squaring and summing, and DATA_W root stages.
- R3: In cheap mode, every valid output carries |Re| + |Im| of its own input sample, 2 edges after acceptance.
- R4: In cheap mode, the most negative input value -2^(DATA_W-1) counts as 2^(DATA_W-1)-1. With DATA_W=6, an input of -32 counts as 31, and (-32,-32) gives 62.
- R5: out_idx equals the in_idx of the sample whose magnitude is on out_mag in the same cycle.
- R6: out_last is high exactly for the output of a sample that was accepted with in_last high. A high in_last on a cycle with in_valid low never reaches the output.
- R7: out_valid repeats the pattern of accepted in_valid exactly one latency later. This holds for back-to-back samples and for gaps alike.
- R8: A synchronous reset drops every sample in flight and the sample presented on the reset edge. out_valid and out_last are low after any reset edge until a sample accepted after the reset reaches the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample present this cycle |
| in_last | input | 1 | Sample ends a frame (only meaningful with in_valid) |
| in_idx | input | IDX_W | Bin number of the sample |
| in_re | input | DATA_W | Real part, two's complement |
| in_im | input | DATA_W | Imaginary part, two's complement |
| out_valid | output | 1 | out_mag, out_idx and out_last hold a result |
| out_last | output | 1 | Result ends a frame |
| out_idx | output | IDX_W | Bin number belonging to out_mag |
| out_mag | output | DATA_W+1 | Magnitude, unsigned |

## Verification
With the bench configuration DATA_W=6, a sample taken on edge e appears after edge e+7 in exact mode, which is 8 edges of latency. In cheap mode it appears after edge e+1, which is 2 edges of latency. The bench logs every accepted sample under the number of its edge. Just after each falling edge it compares each instance's outputs with the log entry one latency earlier. An entry is counted only when it holds a sample that was accepted while reset was low. Reset edges wipe the log, so a flushed sample is expected to stay absent. All 4096 operand pairs are swept, once back to back and once with gaps, and frame-end flags are also driven on idle cycles.

// File: rtl/cmag_pkg.sv
`timescale 1ns/1ps
package cmag_pkg;

   typedef enum logic {
      MAG_EXACT = 1'b0,
      MAG_L1    = 1'b1
   } mag_mode_e;

   localparam int SQSUM_LAT = 2;
   localparam int L1_LAT    = 2;

   function automatic int mag_latency(mag_mode_e mode, int data_w);
      return (mode == MAG_EXACT) ? (SQSUM_LAT + data_w) : L1_LAT;
   endfunction

endpackage

// File: rtl/cmag_sqsum.sv
`timescale 1ns/1ps
module cmag_sqsum #(
   parameter int W = 16
) (
   input  logic                clk,
   input  logic signed [W-1:0] re,
   input  logic signed [W-1:0] im,
   output logic [2*W-1:0]      sum
);
   localparam int PW = 2 * W;

   logic signed [PW-1:0] p_re;
   logic signed [PW-1:0] p_im;
   logic [PW-1:0]        sq_re_q;
   logic [PW-1:0]        sq_im_q;
   logic [PW-1:0]        sum_q;

   assign p_re = re * re;
   assign p_im = im * im;

   // stage 1: squares, stage 2: sum (never exceeds 2^(2W-1))
   always_ff @(posedge clk) begin
      sq_re_q <= p_re;
      sq_im_q <= p_im;
      sum_q   <= sq_re_q + sq_im_q;
   end

   assign sum = sum_q;

endmodule

// File: rtl/cmag_isqrt.sv
`timescale 1ns/1ps
module cmag_isqrt #(
   parameter int N = 16
) (
   input  logic           clk,
   input  logic [2*N-1:0] rad,
   output logic [N-1:0]   root
);
   localparam int DW  = 2 * N;
   localparam int RMW = N + 6;

   logic [DW-1:0]         rad_q  [1:N-1];
   logic signed [RMW-1:0] rem_q  [1:N-1];
   logic [N-1:0]          root_q [1:N];

   for (genvar k = 0; k < N; k++) begin : g_st
      logic [DW-1:0]         rad_i;
      logic signed [RMW-1:0] rem_i;
      logic [N-1:0]          root_i;
      logic signed [RMW-1:0] shifted;
      logic signed [RMW-1:0] trial_sub;
      logic signed [RMW-1:0] trial_add;
      logic signed [RMW-1:0] rem_n;
      logic [N-1:0]          root_n;

      if (k == 0) begin : g_in
         assign rad_i  = rad;
         assign rem_i  = '0;
         assign root_i = '0;
      end else begin : g_mid
         assign rad_i  = rad_q[k];
         assign rem_i  = rem_q[k];
         assign root_i = root_q[k];
      end

      // bring down the next pair of radicand bits
      assign shifted   = (rem_i <<< 2)
                       + $signed({{(RMW-2){1'b0}}, rad_i[DW-1:DW-2]});
      assign trial_sub = $signed({4'b0000, root_i, 2'b01});
      assign trial_add = $signed({4'b0000, root_i, 2'b11});

      // non-restoring: sign of the running remainder picks subtract or add
      assign rem_n  = rem_i[RMW-1] ? (shifted + trial_add) : (shifted - trial_sub);
      assign root_n = (root_i << 1) | {{(N-1){1'b0}}, ~rem_n[RMW-1]};

      always_ff @(posedge clk) begin
         root_q[k+1] <= root_n;
      end

      if (k < N - 1) begin : g_keep
         always_ff @(posedge clk) begin
            rad_q[k+1] <= rad_i << 2;
            rem_q[k+1] <= rem_n;
         end
      end
   end

   assign root = root_q[N];

endmodule

// File: rtl/cmag_l1.sv
`timescale 1ns/1ps
module cmag_l1 #(
   parameter int W = 16
) (
   input  logic                clk,
   input  logic signed [W-1:0] re,
   input  logic signed [W-1:0] im,
   output logic [W:0]          mag
);
   localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
   localparam logic [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

   logic [W-1:0] abs_re;
   logic [W-1:0] abs_im;
   logic [W-1:0] abs_re_q;
   logic [W-1:0] abs_im_q;
   logic [W:0]   mag_q;

   always_comb begin
      if (re == MOST_NEG)  abs_re = MOST_POS;
      else if (re[W-1])    abs_re = -re;
      else                 abs_re = re;
      if (im == MOST_NEG)  abs_im = MOST_POS;
      else if (im[W-1])    abs_im = -im;
      else                 abs_im = im;
   end

   always_ff @(posedge clk) begin
      abs_re_q <= abs_re;
      abs_im_q <= abs_im;
      mag_q    <= {1'b0, abs_re_q} + {1'b0, abs_im_q};
   end

   assign mag = mag_q;

endmodule

// File: rtl/cmag_sideband.sv
`timescale 1ns/1ps
module cmag_sideband #(
   parameter int DEPTH = 18,
   parameter int IDX_W = 14
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic             in_last,
   input  logic [IDX_W-1:0] in_idx,
   output logic             out_valid,
   output logic             out_last,
   output logic [IDX_W-1:0] out_idx
);
   logic [DEPTH-1:0] vld_q;
   logic [DEPTH-1:0] lst_q;
   logic [IDX_W-1:0] idx_q [0:DEPTH-1];

   if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
         if (rst) begin
            vld_q <= '0;
            lst_q <= '0;
         end else begin
            vld_q <= in_valid;
            lst_q <= in_last & in_valid;
         end
      end
   end else begin : g_many
      always_ff @(posedge clk) begin
         if (rst) begin
            vld_q <= '0;
            lst_q <= '0;
         end else begin
            vld_q <= {vld_q[DEPTH-2:0], in_valid};
            lst_q <= {lst_q[DEPTH-2:0], in_last & in_valid};
         end
      end
   end

   always_ff @(posedge clk) begin
      idx_q[0] <= in_idx;
      for (int i = 1; i < DEPTH; i++) idx_q[i] <= idx_q[i-1];
   end

   assign out_valid = vld_q[DEPTH-1];
   assign out_last  = lst_q[DEPTH-1];
   assign out_idx   = idx_q[DEPTH-1];

endmodule

// File: rtl/cmag_unit.sv
`timescale 1ns/1ps
module cmag_unit #(
   parameter int                  DATA_W = 16,
   parameter int                  IDX_W  = 14,
   parameter cmag_pkg::mag_mode_e MODE   = cmag_pkg::MAG_EXACT
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     in_valid,
   input  logic                     in_last,
   input  logic [IDX_W-1:0]         in_idx,
   input  logic signed [DATA_W-1:0] in_re,
   input  logic signed [DATA_W-1:0] in_im,
   output logic                     out_valid,
   output logic                     out_last,
   output logic [IDX_W-1:0]         out_idx,
   output logic [DATA_W:0]          out_mag
);
   localparam int LAT = cmag_pkg::mag_latency(MODE, DATA_W);

   if (DATA_W < 2 || DATA_W > 32) begin : g_bad_data_w
      $error("cmag_unit: DATA_W must lie in 2..32");
   end
   if (IDX_W < 1) begin : g_bad_idx_w
      $error("cmag_unit: IDX_W must be at least 1");
   end

   if (MODE == cmag_pkg::MAG_EXACT) begin : g_exact
      logic [2*DATA_W-1:0] radicand;
      logic [DATA_W-1:0]   root;

      cmag_sqsum #(.W(DATA_W)) u_sqsum (
         .clk (clk),
         .re  (in_re),
         .im  (in_im),
         .sum (radicand)
      );

      cmag_isqrt #(.N(DATA_W)) u_isqrt (
         .clk  (clk),
         .rad  (radicand),
         .root (root)
      );

      assign out_mag = {1'b0, root};
   end else begin : g_l1
      cmag_l1 #(.W(DATA_W)) u_l1 (
         .clk (clk),
         .re  (in_re),
         .im  (in_im),
         .mag (out_mag)
      );
   end

   cmag_sideband #(.DEPTH(LAT), .IDX_W(IDX_W)) u_side (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .in_idx    (in_idx),
      .out_valid (out_valid),
      .out_last  (out_last),
      .out_idx   (out_idx)
   );

endmodule

// File: rtl/cmag_unit_chk.sv
`timescale 1ns/1ps
module cmag_unit_chk #(
   parameter int                  DATA_W = 16,
   parameter int                  IDX_W  = 14,
   parameter cmag_pkg::mag_mode_e MODE   = cmag_pkg::MAG_EXACT
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     in_valid,
   input logic                     in_last,
   input logic [IDX_W-1:0]         in_idx,
   input logic signed [DATA_W-1:0] in_re,
   input logic signed [DATA_W-1:0] in_im,
   input logic                     out_valid,
   input logic                     out_last,
   input logic [IDX_W-1:0]         out_idx,
   input logic [DATA_W:0]          out_mag
);
   localparam int LAT = cmag_pkg::mag_latency(MODE, DATA_W);
   localparam int PW  = 2 * DATA_W + 2;

   // independent record of what entered the block, one latency deep
   logic                     sh_v   [0:LAT-1];
   logic                     sh_l   [0:LAT-1];
   logic [IDX_W-1:0]         sh_idx [0:LAT-1];
   logic signed [DATA_W-1:0] sh_re  [0:LAT-1];
   logic signed [DATA_W-1:0] sh_im  [0:LAT-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < LAT; i++) begin
            sh_v[i] <= 1'b0;
            sh_l[i] <= 1'b0;
         end
      end else begin
         sh_v[0] <= in_valid;
         sh_l[0] <= in_last;
         for (int i = 1; i < LAT; i++) begin
            sh_v[i] <= sh_v[i-1];
            sh_l[i] <= sh_l[i-1];
         end
      end
      sh_idx[0] <= in_idx;
      sh_re[0]  <= in_re;
      sh_im[0]  <= in_im;
      for (int i = 1; i < LAT; i++) begin
         sh_idx[i] <= sh_idx[i-1];
         sh_re[i]  <= sh_re[i-1];
         sh_im[i]  <= sh_im[i-1];
      end
   end

   logic signed [DATA_W-1:0] ref_re;
   logic signed [DATA_W-1:0] ref_im;
   assign ref_re = sh_re[LAT-1];
   assign ref_im = sh_im[LAT-1];

   // R8: nothing survives a reset edge
   p_flush_r8: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && !out_last));

   // R7 (and R2 in exact mode): valid pattern reappears one latency later
   p_valid_delay_r7: assert property (@(posedge clk) disable iff (rst)
      out_valid == sh_v[LAT-1]);

   p_idx_align_r5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_idx == sh_idx[LAT-1]));

   p_last_align_r6: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_last == sh_l[LAT-1]));

   p_last_needs_valid_r6: assert property (@(posedge clk) disable iff (rst)
      out_last |-> out_valid);

   if (MODE == cmag_pkg::MAG_EXACT) begin : g_exact_chk
      logic [PW-1:0] rad_ref;
      logic [PW-1:0] lo_sq;
      logic [PW-1:0] hi_sq;
      assign rad_ref = ref_re * ref_re + ref_im * ref_im;
      assign lo_sq   = out_mag * out_mag;
      assign hi_sq   = (out_mag + 1) * (out_mag + 1);

      p_root_bounds_r1: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> ((lo_sq <= rad_ref) && (hi_sq > rad_ref)));
   end else begin : g_l1_chk
      int a_re;
      int a_im;
      always_comb begin
         a_re = (int'(ref_re) < 0) ? -int'(ref_re) : int'(ref_re);
         a_im = (int'(ref_im) < 0) ? -int'(ref_im) : int'(ref_im);
         if (a_re > (2 ** (DATA_W - 1)) - 1) a_re = (2 ** (DATA_W - 1)) - 1;
         if (a_im > (2 ** (DATA_W - 1)) - 1) a_im = (2 ** (DATA_W - 1)) - 1;
      end

      // R3 value, R4 saturation of the most negative code
      p_l1_value_r3: assert property (@(posedge clk) disable iff (rst)
         out_valid |-> (int'(out_mag) == a_re + a_im));
   end

endmodule

bind cmag_unit cmag_unit_chk #(
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W),
   .MODE   (MODE)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_last   (in_last),
   .in_idx    (in_idx),
   .in_re     (in_re),
   .in_im     (in_im),
   .out_valid (out_valid),
   .out_last  (out_last),
   .out_idx   (out_idx),
   .out_mag   (out_mag)
);

// File: tb/cmag_unit_tb.sv
`timescale 1ns/1ps
module cmag_unit_tb;
   localparam int DW    = 6;
   localparam int IW    = 12;
   localparam int LAT_E = 2 + DW;
   localparam int LAT_C = 2;
   localparam int HN    = 64;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic                 rst;
   logic                 in_valid;
   logic                 in_last;
   logic [IW-1:0]        in_idx;
   logic signed [DW-1:0] in_re;
   logic signed [DW-1:0] in_im;

   logic          e_valid, e_last, c_valid, c_last;
   logic [IW-1:0] e_idx, c_idx;
   logic [DW:0]   e_mag, c_mag;

   cmag_unit #(.DATA_W(DW), .IDX_W(IW), .MODE(cmag_pkg::MAG_EXACT)) u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
      .in_idx(in_idx), .in_re(in_re), .in_im(in_im),
      .out_valid(e_valid), .out_last(e_last), .out_idx(e_idx), .out_mag(e_mag));

   cmag_unit #(.DATA_W(DW), .IDX_W(IW), .MODE(cmag_pkg::MAG_L1)) u_dut_l1 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_last(in_last),
      .in_idx(in_idx), .in_re(in_re), .in_im(in_im),
      .out_valid(c_valid), .out_last(c_last), .out_idx(c_idx), .out_mag(c_mag));

   int checks   = 0;
   int failures = 0;
   int edge_n   = 0;
   bit done     = 1'b0;

   bit hist_v   [HN];
   bit hist_l   [HN];
   int hist_re  [HN];
   int hist_im  [HN];
   int hist_idx [HN];

   function automatic int isqrt_ref(int s);
      int r = 0;
      while ((r + 1) * (r + 1) <= s) r++;
      return r;
   endfunction

   function automatic int abs_sat(int v);
      int a = (v < 0) ? -v : v;
      if (a > (1 << (DW - 1)) - 1) a = (1 << (DW - 1)) - 1;
      return a;
   endfunction

   task automatic check_eq(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", req, what, act, exp, edge_n);
      end
   endtask

   task automatic compare_outputs();
      int se = edge_n - (LAT_E - 1);
      int sc = edge_n - (LAT_C - 1);
      bit ev = (se >= 0) ? hist_v[se % HN] : 1'b0;
      bit cv = (sc >= 0) ? hist_v[sc % HN] : 1'b0;
      // R2: exact-mode result appears 2+DATA_W edges after acceptance
      check_eq("R2", "exact out_valid", int'(e_valid), int'(ev));
      if (ev && e_valid) begin
         int k = se % HN;
         check_eq("R1", "exact magnitude", int'(e_mag),
                  isqrt_ref(hist_re[k] * hist_re[k] + hist_im[k] * hist_im[k]));
         check_eq("R5", "exact out_idx", int'(e_idx), hist_idx[k]);
         check_eq("R6", "exact out_last", int'(e_last), int'(hist_l[k]));
      end else if (!ev) begin
         check_eq("R6", "exact out_last while idle", int'(e_last), 0);
      end
      // R7: cheap-mode valid pattern two edges later
      check_eq("R7", "l1 out_valid", int'(c_valid), int'(cv));
      if (cv && c_valid) begin
         int k = sc % HN;
         bit corner = (hist_re[k] == -(1 << (DW - 1))) || (hist_im[k] == -(1 << (DW - 1)));
         check_eq(corner ? "R4" : "R3", "l1 magnitude", int'(c_mag),
                  abs_sat(hist_re[k]) + abs_sat(hist_im[k]));
         check_eq("R5", "l1 out_idx", int'(c_idx), hist_idx[k]);
         check_eq("R6", "l1 out_last", int'(c_last), int'(hist_l[k]));
      end
   endtask

   // drive at the falling edge, log at the rising edge, compare at the next falling edge
   task automatic tick(bit r, bit v, bit l, int re, int im, int idx);
      rst      = r;
      in_valid = v;
      in_last  = l;
      in_re    = DW'(re);
      in_im    = DW'(im);
      in_idx   = IW'(idx);
      @(posedge clk);
      if (r) begin
         for (int i = 0; i < HN; i++) begin
            hist_v[i] = 1'b0;
            hist_l[i] = 1'b0;
         end
      end
      hist_v[edge_n % HN]   = v && !r;
      hist_l[edge_n % HN]   = l && v && !r;
      hist_re[edge_n % HN]  = re;
      hist_im[edge_n % HN]  = im;
      hist_idx[edge_n % HN] = idx % (1 << IW);
      @(negedge clk);
      compare_outputs();
      edge_n++;
   endtask

   initial begin
      for (int i = 0; i < HN; i++) begin
         hist_v[i] = 1'b0;
         hist_l[i] = 1'b0;
      end
      rst = 1'b1; in_valid = 1'b0; in_last = 1'b0;
      in_idx = '0; in_re = '0; in_im = '0;
      @(negedge clk);
      // reset held while valid junk is presented: it must never appear (R8)
      for (int n = 0; n < 6; n++) tick(1'b1, 1'b1, 1'b1, n - 3, 7 - n, n);
      check_eq("R8", "exact out_valid after reset", int'(e_valid), 0);
      check_eq("R8", "l1 out_valid after reset", int'(c_valid), 0);
      for (int n = 0; n < LAT_E + 2; n++) tick(1'b0, 1'b0, 1'b0, 0, 0, 0);

      // back-to-back sweep of every operand pair
      for (int n = 0; n < 4096; n++)
         tick(1'b0, 1'b1, (n % 64) == 63, ((n >> 6) & 63) - 32, (n & 63) - 32, n);

      // sweep with gaps; frame-end also driven on idle cycles
      for (int n = 0; n < 4096; n++)
         tick(1'b0, (n % 5) != 2, (n % 3) == 0, (n & 63) - 32, ((n >> 6) & 63) - 32, 4095 - n);

      // reset while samples are in flight (R8)
      for (int n = 0; n < 5; n++) tick(1'b0, 1'b1, n == 4, 31 - n, -32 + n, 100 + n);
      tick(1'b1, 1'b1, 1'b1, -32, -32, 7);
      check_eq("R8", "exact out_valid just after mid-run reset", int'(e_valid), 0);
      check_eq("R8", "l1 out_valid just after mid-run reset", int'(c_valid), 0);
      for (int n = 0; n < LAT_E + 4; n++) tick(1'b0, 1'b0, 1'b0, 0, 0, 0);

      // named corner samples (R4 most-negative, R1 extremes)
      tick(1'b0, 1'b1, 1'b0, -32, -32, 1);
      tick(1'b0, 1'b1, 1'b1, -32, 0, 2);
      tick(1'b0, 1'b1, 1'b0, 31, 31, 3);
      tick(1'b0, 1'b1, 1'b1, 0, 0, 4);
      for (int n = 0; n < LAT_E + 2; n++) tick(1'b0, 1'b0, 1'b0, 0, 0, 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL R7 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule